// File: doc/BRIEF.md
# Saturating Adder-Subtractor with Sticky Saturation Flag

This block is a signed saturating arithmetic unit of configurable width (32 bits by default). It takes one operation per accepted transfer. Four operations are supported: addition, subtraction of the first operand from the second, subtraction of the second operand from the first, and subtraction of a sign-extended short immediate from the first operand. When the exact signed result fits in the width, the wrapped result is passed through unchanged. When it does not fit, the output is pinned to the most positive or the most negative representable value. The direction comes from the sign of the wrapped result: a wrapped negative value means the true result was too large, and a wrapped non-negative value means it was too small.

Each result carries four flags. Zero and sign describe the value actually delivered. Carry describes the raw, unclamped add or subtract. Overflow marks every clamped result. The block also holds a sticky saturation bit. Any clamped result sets it, and later ordinary results leave it alone. Only the separate flag-write port changes it otherwise, which models software writing the status register. A flag write and an operation in the same cycle resolve in favour of the write.

Operands enter on a valid/ready port, and results leave on a valid/ready port through a single output register. An operand beat transfers when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result and its flags hold steady and no new operation is taken.

Top module: `satalu_unit`

## Requirements
- R1: Operation code 2'b00 delivers in_b + in_a.
- R2: Operation code 2'b01 delivers in_b - in_a. Code 2'b10 delivers in_a - in_b. Code 2'b11 delivers in_a minus in_imm sign-extended to the full width.
- R3: If the exact signed result exceeds the largest positive value, the output is 0 followed by all ones (e.g. 0x7FFFFFFF), with sign clear and zero clear.
- R4: If the exact signed result is below the most negative value, the output is 1 followed by all zeros (e.g. 0x80000000), with sign set and zero clear.
- R5: Overflow is set exactly when the result is clamped. A result landing exactly on either extreme without exceeding it is neither clamped nor flagged.
- R6: Carry is the carry out of the raw addition. For a subtraction it is set when the unsigned minuend is below the unsigned subtrahend.
- R7: For unclamped results, zero is set when the result is 0, and sign equals the result's top bit.
- R8: The sticky flag sat_sticky becomes 1 after any accepted clamped operation and stays 1 through later non-clamping operations.
- R9: A flag write (flag_wr_en) loads flag_wr_val into sat_sticky on the next cycle. This takes priority over an operation accepted in the same cycle.
- R10: in_ready equals !out_valid || out_ready. A stalled result holds stable, and an operation that is not accepted neither changes the output nor touches sat_sticky.
- R11: After reset, out_valid is 0, sat_sticky is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation beat valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 2 | Operation code (see R1, R2) |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_imm | input | IMM_W | Short immediate, sign-extended for code 2'b11 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | W | Clamped result |
| out_zero | output | 1 | Delivered result is zero |
| out_sign | output | 1 | Delivered result is negative |
| out_carry | output | 1 | Carry/borrow of the raw operation |
| out_ovf | output | 1 | Result was clamped |
| flag_wr_en | input | 1 | Write the sticky flag |
| flag_wr_val | input | 1 | Value for the sticky flag |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
A wrong clamp direction or a wrong overflow decision shows up on out_result and out_ovf one cycle after the offending operation is accepted. That is the next cycle in which out_valid is seen. A corrupt sticky bit shows on sat_sticky one cycle after the accept or flag write that produced it. Because the bit persists, the error stays visible on every later result until a flag write repairs it. A stall bug, in which a held result is overwritten or a refused beat updates the sticky bit, shows within the stall window as a changed out_result or sat_sticky while out_ready is low.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_SUBI = 2'b11
  } sat_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } sat_flags_t;

endpackage

// File: rtl/satalu_core.sv
module satalu_core
  import satalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  sat_op_e          op,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     raw,
  output logic             carry,
  output logic             ovf
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] lhs, rhs, rhs_eff, imm_ext;
  logic         do_sub;
  logic [W:0]   sum;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

  // operand routing: lhs is the minuend for subtractions
  always_comb begin
    lhs    = opnd_b;
    rhs    = opnd_a;
    do_sub = 1'b0;
    unique case (op)
      OP_ADD:  begin lhs = opnd_b; rhs = opnd_a;  do_sub = 1'b0; end
      OP_SUB:  begin lhs = opnd_b; rhs = opnd_a;  do_sub = 1'b1; end
      OP_RSUB: begin lhs = opnd_a; rhs = opnd_b;  do_sub = 1'b1; end
      OP_SUBI: begin lhs = opnd_a; rhs = imm_ext; do_sub = 1'b1; end
      default: ;
    endcase
  end

  // one shared adder: subtraction as lhs + ~rhs + 1
  assign rhs_eff = rhs ^ {W{do_sub}};
  assign sum     = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, do_sub};
  assign raw     = sum[W-1:0];
  // borrow is the absence of carry out when subtracting
  assign carry   = do_sub ? ~sum[W] : sum[W];
  assign ovf     = (lhs[W-1] == rhs_eff[W-1]) && (raw[W-1] != lhs[W-1]);

endmodule

// File: rtl/satalu_clamp.sv
module satalu_clamp
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         raw_carry,
  input  logic         raw_ovf,
  output logic [W-1:0] result,
  output sat_flags_t   flags
);
  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (raw_ovf) begin
      // a wrapped negative value means the true sum ran past the top
      result = raw[W-1] ? POS_LIMIT : NEG_LIMIT;
    end else begin
      result = raw;
    end
    flags.zero  = ~raw_ovf & (raw == '0);
    flags.sign  = result[W-1];
    flags.carry = raw_carry;
    flags.ovf   = raw_ovf;
  end

endmodule

// File: rtl/satalu_sticky.sv
module satalu_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic accept,
  input  logic sat_in,
  output logic sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sticky <= 1'b0;
    else if (wr_en)            sticky <= wr_val;
    else if (accept && sat_in) sticky <= 1'b1;
  end

  // R9
  flag_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sticky == $past(wr_val)));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !wr_en) |=> sticky);

  // R10
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !accept) |=> $stable(sticky));

endmodule

// File: rtl/satalu_stage.sv
module satalu_stage
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_result,
  input  sat_flags_t   d_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output sat_flags_t   out_flags,
  output logic         accept
);
  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= d_result;
        out_flags  <= d_flags;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  // R3
  sat_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags.ovf) |->
      ((out_result == POS_LIMIT && !out_flags.sign) || (out_result == NEG_LIMIT && out_flags.sign)));

  // R5
  sat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags.ovf) |-> !out_flags.zero);

endmodule

// File: rtl/satalu_unit.sv
module satalu_unit
  import satalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_zero,
  output logic             out_sign,
  output logic             out_carry,
  output logic             out_ovf,
  input  logic             flag_wr_en,
  input  logic             flag_wr_val,
  output logic             sat_sticky
);
  logic [W-1:0] raw, clamped;
  logic         raw_carry, raw_ovf, accept;
  sat_flags_t   d_flags, q_flags;

  satalu_core #(.W(W), .IMM_W(IMM_W)) u_core (
    .op(sat_op_e'(in_op)), .opnd_a(in_a), .opnd_b(in_b), .imm(in_imm),
    .raw(raw), .carry(raw_carry), .ovf(raw_ovf)
  );

  satalu_clamp #(.W(W)) u_clamp (
    .raw(raw), .raw_carry(raw_carry), .raw_ovf(raw_ovf),
    .result(clamped), .flags(d_flags)
  );

  satalu_stage #(.W(W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_result(clamped), .d_flags(d_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(q_flags), .accept(accept)
  );

  satalu_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .wr_en(flag_wr_en), .wr_val(flag_wr_val),
    .accept(accept), .sat_in(raw_ovf), .sticky(sat_sticky)
  );

  assign out_zero  = q_flags.zero;
  assign out_sign  = q_flags.sign;
  assign out_carry = q_flags.carry;
  assign out_ovf   = q_flags.ovf;

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !sat_sticky));

endmodule

// File: tb/sim_satalu_unit.sv
`timescale 1ns/1ps
module sim_satalu_unit;
  localparam int W     = 6;
  localparam int IMM_W = 4;
  localparam int SPAN  = 1 << W;
  localparam int ISPAN = 1 << IMM_W;
  localparam int MAXS  = SPAN/2 - 1;
  localparam int MINS  = -(SPAN/2);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [1:0] in_op;
  logic [W-1:0] in_a, in_b, out_result;
  logic [IMM_W-1:0] in_imm;
  logic out_zero, out_sign, out_carry, out_ovf, flag_wr_en, flag_wr_val, sat_sticky;

  satalu_unit #(.W(W), .IMM_W(IMM_W)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit model_sticky = 1'b0;
  bit done = 1'b0;

  function automatic int sgn(int u, int w);
    return (u >= (1 << (w-1))) ? u - (1 << w) : u;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] observed();
    return {52'd0, out_result, out_zero, out_sign, out_carry, out_ovf, sat_sticky};
  endfunction

  // called at a negedge; leaves at the next negedge with the result checked
  task automatic run_op(int op, int a, int b, int imm);
    int ux, uy, sx, sy, exact, uraw, res;
    bit c, ov, ez, es;
    string tag;
    case (op)
      0, 1:    begin ux = b; uy = a; end
      2:       begin ux = a; uy = b; end
      default: begin ux = a; uy = (sgn(imm, IMM_W) + SPAN) % SPAN; end
    endcase
    sx = sgn(ux, W);
    sy = sgn(uy, W);
    if (op == 0) begin
      exact = sx + sy; c = (ux + uy) >= SPAN; uraw = (ux + uy) % SPAN;
    end else begin
      exact = sx - sy; c = ux < uy; uraw = (ux - uy + SPAN) % SPAN;
    end
    ov = (exact > MAXS) || (exact < MINS);
    res = ov ? ((exact > 0) ? MAXS : SPAN/2) : uraw;
    ez = (res == 0);
    es = (res >= SPAN/2);
    model_sticky = model_sticky | ov;
    if (ov) tag = (exact > 0) ? "R3/R5/R6/R8" : "R4/R5/R6/R8";
    else    tag = (op == 0) ? "R1/R5/R6/R7" : "R2/R5/R6/R7";
    in_op = op[1:0]; in_a = a[W-1:0]; in_b = b[W-1:0]; in_imm = imm[IMM_W-1:0];
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, observed(),
          {52'd0, res[W-1:0], ez, es, c, ov, model_sticky});
  endtask

  task automatic write_flag(bit v);
    flag_wr_en = 1'b1; flag_wr_val = v;
    @(posedge clk);
    @(negedge clk);
    flag_wr_en = 1'b0;
    model_sticky = v;
    check("R9 flag write", {63'd0, sat_sticky}, {63'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_op = '0;
    in_a = '0; in_b = '0; in_imm = '0; flag_wr_en = 1'b0; flag_wr_val = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {61'd0, out_valid, sat_sticky, in_ready}, {61'd0, 3'b001});
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {61'd0, out_valid, sat_sticky, in_ready}, {61'd0, 3'b001});

    // R9: set, then clear in the same cycle as a clamping operation
    write_flag(1'b1);
    flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    in_op = 2'b00; in_a = 6'h1C; in_b = 6'h1C; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; flag_wr_en = 1'b0; model_sticky = 1'b0;
    check("R9 write beats op", {62'd0, out_ovf, sat_sticky}, {62'd0, 2'b10});
    check("R3 same-cycle result", {58'd0, out_result}, {58'd0, 6'h1F});

    // exhaustive sweeps of all register operations
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
          run_op(op, a, b, 0);
    // immediate form over every immediate
    write_flag(1'b0);
    for (int a = 0; a < SPAN; a++)
      for (int i = 0; i < ISPAN; i++)
        run_op(3, a, 0, i);

    // R8 persistence: clamp once, then an ordinary op keeps the flag
    write_flag(1'b0);
    run_op(0, 6'h10, 6'h10, 0);
    run_op(0, 1, 2, 0);
    check("R8 sticky persists", {63'd0, sat_sticky}, 64'd1);

    // R10 back-pressure
    write_flag(1'b0);
    out_ready = 1'b0;
    in_op = 2'b00; in_a = 6'd1; in_b = 6'd2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 first result", {57'd0, out_valid, out_result}, {57'd0, 1'b1, 6'd3});
    in_a = 6'h1C; in_b = 6'h1C;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R10 stall", {56'd0, in_ready, out_result, sat_sticky},
            {56'd0, 1'b0, 6'd3, 1'b0});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 drained", {56'd0, out_result, out_ovf, sat_sticky},
          {56'd0, 6'h1F, 1'b1, 1'b1});
    @(posedge clk);
    @(negedge clk);
    check("R10 empty", {62'd0, out_valid, in_ready}, {62'd0, 2'b01});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule